// File: doc/BRIEF.md
# Match Timer with PWM Outputs

This block is a prescaled timer counter with four compare channels. Software programs it through a simple word-addressed write port and a registered read port. A separate count-control unit supplies an increment strobe. On each strobe, while the counter is enabled and not held in reset, the prescale counter advances. When the prescale counter reaches its limit, the timer counter takes one step.

Every compare channel watches the timer counter. When the counter sits at a channel's compare value as a step occurs, the channel can do any mix of three things: raise its interrupt flag, send the counter back to zero, or stop counting. It can also drive its match pin low, drive it high or toggle it.

In PWM mode, one channel that is set to reset the counter defines the period. Every PWM-enabled channel is then low at the start of each cycle and goes high once the counter reaches that channel's compare value.

Top module: `match_pwm_timer`

Register word addresses on `wr_addr` / `rd_addr`:
- 0: control. Bit 0 is run, bit 1 is hold-clear.
- 1: prescale limit.
- 2: match actions. Channel i uses bits 3i..3i+2: +0 flag, +1 reset counter, +2 stop.
- 3: pin control. Bits 0..3 hold the pin states. Channel i's pin action sits at bits 4+2i..5+2i.
- 4: PWM enables, one bit per channel.
- 5: flags. Bit i belongs to channel i.
- 6: timer counter.
- 7: prescale counter (read only).
- 8..11: compare values for channels 0..3.

## Requirements
- R1: After reset every register, the counter, the prescale counter, all pins, `irq` and `rd_data` are zero.
- R2: Control bit 0 enables counting; writing 0 to the control register pauses the counter and keeps its value.
- R3: While control bit 1 is set, the timer counter and the prescale counter are held at zero.
- R4: With prescale limit P and the strobe high every clock, the counter advances once every P+1 enabled clocks, and P=0 gives one step per clock.
- R5: A step taken while the counter equals a channel's compare value, with that channel's flag action bit set, sets flag bit i; `irq` is high while any flag is set.
- R6: Writing 1 to a flag bit clears it; writing 0 leaves it unchanged.
- R7: A step at the compare value of a channel with the reset action bit set returns the counter to 0, so the count period is compare value + 1.
- R8: A step at the compare value of a channel with the stop action bit set clears control bit 0, and the counter holds the compare value.
- R9: At a match step the pin action code acts on the channel's pin: 00 leaves it, 01 drives it low, 10 drives it high, 11 toggles it.
- R10: A PWM-enabled channel's output is high exactly while the counter is at or above its compare value. A compare value of 0 gives a constant high output, and a value above the period gives a constant low output. A disabled channel outputs low.
- R11: With a 16-bit counter only channels 0 and 1 drive `match_pins`; bits 2 and 3 stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_strobe | input | 1 | Count qualifier from the count-control unit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | CNT_W | Read data, registered one cycle after `rd_addr` |
| match_pins | output | NCH | External match pin states |
| pwm_pins | output | NCH | PWM outputs |
| irq | output | 1 | High while any flag is set |

## Verification
The assertions check, on every cycle, the rules that hold within one or two clocks:
- the counter is held at zero while hold-clear is set and stays frozen while paused;
- a reset-on-match step zeroes the counter and a stop step clears run;
- the prescale counter wraps after a step;
- writing 1 clears a flag;
- toggle flips a pin;
- a zero compare value drives PWM high.

Only the bench scenarios can show the behaviour that builds up over many steps: the division ratio for several prescale limits, the count period under reset-on-match, the mixed pin codes after one pass, full PWM waveforms against a period channel, and the pins that the 16-bit variant does not expose.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_PRE  = 4'd1;
  localparam logic [3:0] A_MACT = 4'd2;
  localparam logic [3:0] A_PIN  = 4'd3;
  localparam logic [3:0] A_PWM  = 4'd4;
  localparam logic [3:0] A_FLAG = 4'd5;
  localparam logic [3:0] A_CNT  = 4'd6;
  localparam logic [3:0] A_PCNT = 4'd7;
  localparam logic [3:0] A_MAT0 = 4'd8;

  localparam int ACT_FLAG = 0;
  localparam int ACT_RST  = 1;
  localparam int ACT_STOP = 2;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'b00,
    PIN_LOW    = 2'b01,
    PIN_HIGH   = 2'b10,
    PIN_TOGGLE = 2'b11
  } pin_act_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic [W-1:0] pc,
  output logic         step
);
  logic wrap;
  assign wrap = (pc >= limit);
  assign step = tick & wrap & ~clr;

  always_ff @(posedge clk) begin
    if (rst || clr)   pc <= '0;
    else if (tick) begin
      if (wrap)       pc <= '0;
      else            pc <= pc + 1'b1;
    end
  end

  // R4
  pc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (pc == '0));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] tc,
  input  logic [W-1:0] tc_nxt,
  input  logic         step,
  input  logic [W-1:0] mval,
  input  logic [1:0]   pin_act,
  input  logic         pwm_en,
  input  logic         pin_wr,
  input  logic         pin_wval,
  output logic         hit,
  output logic         pin_q,
  output logic         pwm_q
);
  import tmr_pkg::*;

  assign hit = step && (tc == mval);

  always_ff @(posedge clk) begin
    if (rst)         pin_q <= 1'b0;
    else if (pin_wr) pin_q <= pin_wval;
    else if (hit) begin
      case (pin_act_e'(pin_act))
        PIN_LOW:    pin_q <= 1'b0;
        PIN_HIGH:   pin_q <= 1'b1;
        PIN_TOGGLE: pin_q <= ~pin_q;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= pwm_en && (tc_nxt >= mval);
  end

  // R9
  toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && pin_act == 2'b11 && !pin_wr) |=> (pin_q != $past(pin_q)));
  // R10
  pwm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_en && mval == '0) |=> pwm_q);
endmodule

// File: rtl/match_pwm_timer.sv
module match_pwm_timer #(
  parameter int CNT_W = 32,
  parameter int NCH   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_strobe,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [3:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [NCH-1:0]   match_pins,
  output logic [NCH-1:0]   pwm_pins,
  output logic             irq
);
  import tmr_pkg::*;

  localparam int PIN_CH = (CNT_W == 16) ? 2 : NCH;
  localparam int ACT_W  = 3 * NCH;
  localparam int PACT_W = 2 * NCH;

  logic [1:0]        ctrl_q;
  logic [CNT_W-1:0]  pre_q;
  logic [ACT_W-1:0]  mact_q;
  logic [PACT_W-1:0] pact_q;
  logic [NCH-1:0]    pwm_en_q;
  logic [NCH-1:0]    flag_q, flag_d;
  logic [CNT_W-1:0]  tc_q, tc_nxt, pc;
  logic [CNT_W-1:0]  mval_q [NCH];
  logic              irq_q;

  logic crst, tick, step;
  logic [NCH-1:0] hit, rst_mask, stop_mask, flag_mask, pin_q, pwm_q;
  logic rst_hit, stop_hit, cnt_wr, ctrl_wr, flag_wr, pin_wr;

  assign crst    = ctrl_q[1];
  assign tick    = inc_strobe & ctrl_q[0] & ~crst;
  assign cnt_wr  = wr_en && (wr_addr == A_CNT);
  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign flag_wr = wr_en && (wr_addr == A_FLAG);
  assign pin_wr  = wr_en && (wr_addr == A_PIN);

  tmr_prescale #(.W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .clr(crst), .tick(tick),
    .limit(pre_q), .pc(pc), .step(step)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign rst_mask[i]  = hit[i] & mact_q[3*i+ACT_RST];
    assign stop_mask[i] = hit[i] & mact_q[3*i+ACT_STOP];
    assign flag_mask[i] = hit[i] & mact_q[3*i+ACT_FLAG];

    tmr_chan #(.W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .tc(tc_q), .tc_nxt(tc_nxt), .step(step),
      .mval(mval_q[i]), .pin_act(pact_q[2*i +: 2]), .pwm_en(pwm_en_q[i]),
      .pin_wr(pin_wr), .pin_wval(wr_data[i]),
      .hit(hit[i]), .pin_q(pin_q[i]), .pwm_q(pwm_q[i])
    );

    always_ff @(posedge clk) begin
      if (rst) mval_q[i] <= '0;
      else if (wr_en && wr_addr == 4'(8 + i)) mval_q[i] <= wr_data;
    end

    if (i < PIN_CH) begin : g_pin
      assign match_pins[i] = pin_q[i];
    end else begin : g_nopin
      assign match_pins[i] = 1'b0;
    end
  end

  assign rst_hit  = |rst_mask;
  assign stop_hit = |stop_mask;
  assign pwm_pins = pwm_q;
  assign irq      = irq_q;

  always_comb begin
    if (crst)                    tc_nxt = '0;
    else if (cnt_wr)             tc_nxt = wr_data;
    else if (rst_hit)            tc_nxt = '0;
    else if (step && !stop_hit)  tc_nxt = tc_q + 1'b1;
    else                         tc_nxt = tc_q;
  end

  assign flag_d = (flag_q & ~(flag_wr ? wr_data[NCH-1:0] : '0)) | flag_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      pre_q    <= '0;
      mact_q   <= '0;
      pact_q   <= '0;
      pwm_en_q <= '0;
      flag_q   <= '0;
      irq_q    <= 1'b0;
      tc_q     <= '0;
    end else begin
      tc_q   <= tc_nxt;
      flag_q <= flag_d;
      irq_q  <= |flag_d;
      if (ctrl_wr)       ctrl_q    <= wr_data[1:0];
      else if (stop_hit) ctrl_q[0] <= 1'b0;
      if (wr_en && wr_addr == A_PRE)  pre_q    <= wr_data;
      if (wr_en && wr_addr == A_MACT) mact_q   <= wr_data[ACT_W-1:0];
      if (pin_wr)                     pact_q   <= wr_data[NCH +: PACT_W];
      if (wr_en && wr_addr == A_PWM)  pwm_en_q <= wr_data[NCH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_CTRL:  rd_data <= CNT_W'(ctrl_q);
        A_PRE:   rd_data <= pre_q;
        A_MACT:  rd_data <= CNT_W'(mact_q);
        A_PIN:   rd_data <= CNT_W'({pact_q, pin_q});
        A_PWM:   rd_data <= CNT_W'(pwm_en_q);
        A_FLAG:  rd_data <= CNT_W'(flag_q);
        A_CNT:   rd_data <= tc_q;
        A_PCNT:  rd_data <= pc;
        default: begin
          rd_data <= '0;
          for (int k = 0; k < NCH; k++)
            if (rd_addr == 4'(8 + k)) rd_data <= mval_q[k];
        end
      endcase
    end
  end

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    crst |=> (tc_q == '0));
  // R2
  pause_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[0] && !crst && !cnt_wr) |=> $stable(tc_q));
  // R7
  rst_match_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_hit && !cnt_wr) |=> (tc_q == '0));
  // R8
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_hit && !ctrl_wr) |=> !ctrl_q[0]);
  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && wr_data[0] && !hit[0]) |=> !flag_q[0]);
endmodule

// File: tb/sim_match_pwm_timer.sv
`timescale 1ns/1ps
module sim_match_pwm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inc_strobe = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] rd_data16;
  logic [3:0]  match_pins, pwm_pins, match_pins16, pwm_pins16;
  logic        irq, irq16;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  match_pwm_timer #(.CNT_W(32), .NCH(4)) u0 (
    .clk(clk), .rst(rst), .inc_strobe(inc_strobe), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .match_pins(match_pins), .pwm_pins(pwm_pins), .irq(irq)
  );

  match_pwm_timer #(.CNT_W(16), .NCH(4)) u1 (
    .clk(clk), .rst(rst), .inc_strobe(inc_strobe), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data[15:0]), .rd_addr(rd_addr),
    .rd_data(rd_data16), .match_pins(match_pins16), .pwm_pins(pwm_pins16), .irq(irq16)
  );

  // prescale limit, clocks waited, expected counter, expected prescale counter
  localparam logic [31:0] VEC [4][4] = '{
    '{32'd0, 32'd9,  32'd10, 32'd0},
    '{32'd1, 32'd9,  32'd5,  32'd0},
    '{32'd3, 32'd10, 32'd2,  32'd3},
    '{32'd4, 32'd14, 32'd3,  32'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic run_for(input int n);
    wr(4'd0, 32'd1);
    repeat (n) @(negedge clk);
    wr(4'd0, 32'd0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pins", {match_pins, pwm_pins, 3'b0, irq}, 32'd0);
    rd(4'd6, v); check("R1 counter", v, 32'd0);
    rd(4'd0, v); check("R1 control", v, 32'd0);

    // R4 / R2: prescale ratios, pause holds value
    for (int i = 0; i < 4; i++) begin
      wr(4'd0, 32'd2);
      wr(4'd1, VEC[i][0]);
      run_for(int'(VEC[i][1]));
      rd(4'd6, v); check("R4 counter", v, VEC[i][2]);
      rd(4'd7, v); check("R4 prescale counter", v, VEC[i][3]);
      repeat (5) @(negedge clk);
      rd(4'd6, v); check("R2 paused counter", v, VEC[i][2]);
    end

    // R3 hold-clear zeroes counter and prescaler
    wr(4'd0, 32'd3);
    repeat (4) @(negedge clk);
    rd(4'd6, v); check("R3 counter held", v, 32'd0);
    rd(4'd7, v); check("R3 prescale held", v, 32'd0);

    // R7 / R5 / R6: channel 0 reset+flag at 4, period 5
    wr(4'd1, 32'd0);
    wr(4'd5, 32'hF);
    wr(4'd2, 32'h3);
    wr(4'd8, 32'd4);
    wr(4'd0, 32'd2);
    run_for(12);
    rd(4'd6, v); check("R7 counter mod period", v, 32'd3);
    rd(4'd5, v); check("R5 flag set", v, 32'd1);
    check("R5 irq high", {31'd0, irq}, 32'd1);
    wr(4'd5, 32'd0);
    rd(4'd5, v); check("R6 write 0 keeps flag", v, 32'd1);
    wr(4'd5, 32'd1);
    check("R6 irq cleared", {31'd0, irq}, 32'd0);
    rd(4'd5, v); check("R6 flag cleared", v, 32'd0);

    // R8 stop on channel 1 at 6
    wr(4'd0, 32'd2);
    wr(4'd2, 32'h20);
    wr(4'd9, 32'd6);
    wr(4'd0, 32'd1);
    repeat (20) @(negedge clk);
    rd(4'd6, v); check("R8 counter stopped", v, 32'd6);
    rd(4'd0, v); check("R8 run cleared", v, 32'd0);

    // R9 / R11 pin codes: toggle, high, low, keep
    wr(4'd0, 32'd2);
    wr(4'd2, 32'h0);
    for (int i = 0; i < 4; i++) wr(4'(8 + i), 32'd2);
    wr(4'd3, 32'h1BC);
    run_for(8);
    check("R9 pin codes", {28'd0, match_pins}, 32'hB);
    check("R11 16-bit pins", {28'd0, match_pins16}, 32'h3);

    // R10 PWM: period on ch3 (9), duties 3, 0, 20
    wr(4'd0, 32'd2);
    wr(4'd3, 32'h0);
    wr(4'd2, 32'h400);
    wr(4'd8, 32'd3);
    wr(4'd9, 32'd0);
    wr(4'd10, 32'd20);
    wr(4'd11, 32'd9);
    wr(4'd4, 32'h7);
    wr(4'd0, 32'd1);
    for (int k = 0; k < 25; k++) begin
      check("R10 pwm", {28'd0, pwm_pins},
            {28'd0, 1'b0, 1'b0, 1'b1, ((k % 10) >= 3)});
      @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule